// File: doc/BRIEF.md
# Event Match Timer Core

This block is a free-running timer whose period comes from its own match logic and not from a fixed terminal count. A single 32-bit counter runs against a bank of sixteen match registers. Sixteen event slots each pick one match register and compare it with the counter. An event bit pulses for one clock when the chosen value equals the counter. A limit mask names the events that end a period. When one of those events fires, the counter restarts from zero, or in bidirectional mode turns and counts back down to zero.

Each match register has a shadow (reload) register. At every period boundary the shadows are copied into the live match registers, so software can prepare the next period's values without tearing the current one. A configuration bit can suppress this copy. An 8-bit prescaler slows the count, a halt bit freezes it, and a direction bit selects up-only or up/down counting. Everything is programmed through a plain word-addressed write port and a combinational read port. Outside logic consumes the 16-bit event-pulse vector.

Top module: `event_match_timer`

## Requirements
- R1: After reset the counter is 0, the event vector is 0, the control word reads 0x4 (halted), and the configuration, limit, match, reload, event-control and state-mask registers read 0.
- R2: The address is split into a group in bits 7:4 and an index in bits 3:0. Group 0 holds configuration (index 0), control (index 1), limit mask (index 2) and counter (index 3). Groups 1, 2, 3 and 4 hold match n, reload n, event-control n and state-mask n, and each reads back what was written to its defined bits.
- R3: The counter advances only while configuration bit 0 (unified 32-bit mode) is 1 and control bit 2 (halt) is 0. With a prescale of 0 it moves once per clock.
- R4: Control bits 12:5 hold a prescale value P. While running, the counter moves once every P+1 clocks.
- R5: Event n is armed when bits 13:12 of its control word equal 01 and bit 0 of its state mask is 1. Bits 3:0 of the control word select the match register it compares. A control word of 0 or a clear state-mask bit 0 keeps the event silent.
- R6: An armed event whose selected match value equals the counter raises its bit of the event vector one clock after the counter first shows that value. The bit lasts exactly one clock per count value, however long the prescaler holds the count.
- R7: When an event whose bit is set in the limit mask fires during up-only counting, the next count step loads 0. A match value of N-1 therefore gives a period of N count steps.
- R8: At each period boundary every match register takes its reload value, unless configuration bit 7 is 1. A write to a match register in the same clock as a boundary takes priority over the reload.
- R9: With control bit 4 set, the counter counts up to the limit match, then counts down to 0, then counts up again. The boundary (reload point) is the turn at 0.
- R10: While halted the counter holds its value and the event vector stays 0, and register writes still take effect.
- R11: A write to the counter address loads the counter on the next clock, taking priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register |
| wr_addr | input | 8 | Write address (group in 7:4, index in 3:0) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |
| ev_out | output | 16 | One-clock event pulses, bit n for event n |

## Verification
The two functions that can land in the same clock are the period-boundary reload of the match registers and a software write to one of them. The bench programs a short period, counts clock edges from the run command, and times a match write so it is latched on exactly the edge where the limit event restarts the counter. It then halts the timer and reads the register back. The written value must be present, not the reload value that the boundary would otherwise have copied. The same ordering rule is used for counter loads against count steps when the bench moves the counter between test phases.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  // address groups (wr_addr/rd_addr bits 7:4)
  localparam logic [3:0] GRP_CORE   = 4'h0;
  localparam logic [3:0] GRP_MATCH  = 4'h1;
  localparam logic [3:0] GRP_RELOAD = 4'h2;
  localparam logic [3:0] GRP_EVCTL  = 4'h3;
  localparam logic [3:0] GRP_SMASK  = 4'h4;

  // indices inside the core group
  localparam logic [3:0] IDX_CFG   = 4'h0;
  localparam logic [3:0] IDX_CTRL  = 4'h1;
  localparam logic [3:0] IDX_LIMIT = 4'h2;
  localparam logic [3:0] IDX_COUNT = 4'h3;

  // field positions
  localparam int CFG_UNIFY_BIT  = 0;
  localparam int CFG_NOREL_BIT  = 7;
  localparam int CTRL_HALT_BIT  = 2;
  localparam int CTRL_BIDIR_BIT = 4;
  localparam int CTRL_PRE_LSB   = 5;
  localparam int EVC_MODE_LSB   = 12;

  localparam logic [1:0] EVC_MODE_MATCH = 2'b01;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

endpackage

// File: rtl/etm_prescale.sv
module etm_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_val,
  output logic             tick
);

  logic [PRE_W-1:0] pre_cnt;

  // ">=" lets a lowered prescale take effect without a wrap-around
  assign tick = run && (pre_cnt >= pre_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else if (run)  pre_cnt <= pre_cnt + 1'b1;
  end

  // R4: a nonzero prescale never yields back-to-back ticks
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_val != '0) |=> (!tick || pre_val == '0));

endmodule

// File: rtl/etm_counter.sv
module etm_counter
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bidir,
  input  logic             limit_hit,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary
);

  dir_e dir;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic down);
    return down ? v - 1'b1 : v + 1'b1;
  endfunction

  always_comb begin
    boundary = 1'b0;
    if (tick && !load_en) begin
      if (!bidir)                          boundary = limit_hit;
      else if (dir == DIR_DOWN && cnt == '0) boundary = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else if (load_en) begin
      cnt <= load_val;
    end else if (tick) begin
      if (!bidir) begin
        dir <= DIR_UP;
        cnt <= limit_hit ? '0 : step(cnt, 1'b0);
      end else if (dir == DIR_UP) begin
        if (limit_hit && cnt != '0) begin
          dir <= DIR_DOWN;
          cnt <= step(cnt, 1'b1);
        end else begin
          cnt <= step(cnt, 1'b0);
        end
      end else if (cnt == '0) begin
        dir <= DIR_UP;
        cnt <= step(cnt, 1'b0);
      end else begin
        cnt <= step(cnt, 1'b1);
      end
    end
  end

  // R10: without a step or a load the value is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> (cnt == $past(cnt)));

  // R7: a limit step in up-only mode lands on zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && !bidir && limit_hit) |=> (cnt == '0));

  // R11: a load wins over counting
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt == $past(load_val)));

  // R9: the down-count turns at zero and climbs again
  p_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && bidir) |=> (cnt == {{(CNT_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/etm_events.sv
module etm_events
  import evt_tmr_pkg::*;
#(
  parameter int NUM_EV    = 16,
  parameter int NUM_MATCH = 16,
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run,
  input  logic                            tick,
  input  logic                            load_en,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_vals,
  input  logic [NUM_EV-1:0][SEL_W-1:0]    ev_sel,
  input  logic [NUM_EV-1:0][1:0]          ev_mode,
  input  logic [NUM_EV-1:0]               state_ok,
  output logic [NUM_EV-1:0]               hit,
  output logic [NUM_EV-1:0]               pulse
);

  logic fresh;  // current count value has not yet produced its pulses

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cmp
    assign hit[g] = (ev_mode[g] == EVC_MODE_MATCH) && state_ok[g] &&
                    (match_vals[ev_sel[g]] == cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh <= 1'b1;
      pulse <= '0;
    end else begin
      pulse <= (run && fresh) ? hit : '0;
      if (tick || load_en) fresh <= 1'b1;
      else if (run)        fresh <= 1'b0;
    end
  end

  // R10: a halted cycle is followed by a silent event vector
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pulse == '0));

  // R6: a count value that is not renewed cannot pulse twice
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !load_en) |=> ##1 (pulse == '0));

endmodule

// File: rtl/event_match_timer.sv
module event_match_timer
  import evt_tmr_pkg::*;
#(
  parameter int NUM_EV    = 16,
  parameter int NUM_MATCH = 16,
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 8,
  parameter int STATE_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [15:0] ev_out
);

  localparam int SEL_W = $clog2(NUM_MATCH);

  logic [3:0] wr_grp, wr_idx, rd_grp, rd_idx;
  assign wr_grp = wr_addr[7:4];
  assign wr_idx = wr_addr[3:0];
  assign rd_grp = rd_addr[7:4];
  assign rd_idx = rd_addr[3:0];

  logic cfg_unify, cfg_norel, halt_q, bidir_q;
  logic [PRE_W-1:0]  pre_q;
  logic [NUM_EV-1:0] limit_q;

  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q, reload_q;
  logic [NUM_EV-1:0][SEL_W-1:0]    ev_sel_q;
  logic [NUM_EV-1:0][1:0]          ev_mode_q;
  logic [NUM_EV-1:0][STATE_W-1:0]  smask_q;
  logic [NUM_EV-1:0]               state_ok;

  logic core_wr, load_en, run, tick, limit_hit, boundary;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_EV-1:0] hit, pulse;

  assign core_wr   = wr_en && (wr_grp == GRP_CORE);
  assign load_en   = core_wr && (wr_idx == IDX_COUNT);
  assign run       = cfg_unify && !halt_q;
  assign limit_hit = |(hit & limit_q);
  assign ev_out    = pulse;

  for (genvar e = 0; e < NUM_EV; e++) begin : g_state
    assign state_ok[e] = smask_q[e][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_unify <= 1'b0;
      cfg_norel <= 1'b0;
      halt_q    <= 1'b1;
      bidir_q   <= 1'b0;
      pre_q     <= '0;
      limit_q   <= '0;
    end else if (core_wr) begin
      case (wr_idx)
        IDX_CFG: begin
          cfg_unify <= wr_data[CFG_UNIFY_BIT];
          cfg_norel <= wr_data[CFG_NOREL_BIT];
        end
        IDX_CTRL: begin
          halt_q  <= wr_data[CTRL_HALT_BIT];
          bidir_q <= wr_data[CTRL_BIDIR_BIT];
          pre_q   <= wr_data[CTRL_PRE_LSB +: PRE_W];
        end
        IDX_LIMIT: limit_q <= wr_data[NUM_EV-1:0];
        default: ;
      endcase
    end
  end

  // match registers: software write first, then the boundary reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      reload_q <= '0;
    end else begin
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (wr_en && wr_grp == GRP_MATCH && wr_idx == 4'(i))
          match_q[i] <= wr_data[CNT_W-1:0];
        else if (boundary && !cfg_norel)
          match_q[i] <= reload_q[i];
        if (wr_en && wr_grp == GRP_RELOAD && wr_idx == 4'(i))
          reload_q[i] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_sel_q  <= '0;
      ev_mode_q <= '0;
      smask_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_EV; i++) begin
        if (wr_en && wr_grp == GRP_EVCTL && wr_idx == 4'(i)) begin
          ev_sel_q[i]  <= wr_data[SEL_W-1:0];
          ev_mode_q[i] <= wr_data[EVC_MODE_LSB +: 2];
        end
        if (wr_en && wr_grp == GRP_SMASK && wr_idx == 4'(i))
          smask_q[i] <= wr_data[STATE_W-1:0];
      end
    end
  end

  etm_prescale #(.PRE_W(PRE_W)) i_prescale (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_val(pre_q), .tick(tick)
  );

  etm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bidir(bidir_q),
    .limit_hit(limit_hit), .load_en(load_en), .load_val(wr_data[CNT_W-1:0]),
    .cnt(cnt), .boundary(boundary)
  );

  etm_events #(.NUM_EV(NUM_EV), .NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W), .SEL_W(SEL_W)) i_events (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load_en(load_en),
    .cnt(cnt), .match_vals(match_q), .ev_sel(ev_sel_q), .ev_mode(ev_mode_q),
    .state_ok(state_ok), .hit(hit), .pulse(pulse)
  );

  always_comb begin
    rd_data = '0;
    case (rd_grp)
      GRP_CORE: begin
        case (rd_idx)
          IDX_CFG: begin
            rd_data[CFG_UNIFY_BIT] = cfg_unify;
            rd_data[CFG_NOREL_BIT] = cfg_norel;
          end
          IDX_CTRL: begin
            rd_data[CTRL_HALT_BIT]            = halt_q;
            rd_data[CTRL_BIDIR_BIT]           = bidir_q;
            rd_data[CTRL_PRE_LSB +: PRE_W]    = pre_q;
          end
          IDX_LIMIT: rd_data[NUM_EV-1:0] = limit_q;
          IDX_COUNT: rd_data[CNT_W-1:0]  = cnt;
          default: ;
        endcase
      end
      GRP_MATCH:  rd_data[CNT_W-1:0] = match_q[rd_idx];
      GRP_RELOAD: rd_data[CNT_W-1:0] = reload_q[rd_idx];
      GRP_EVCTL: begin
        rd_data[EVC_MODE_LSB +: 2] = ev_mode_q[rd_idx];
        rd_data[SEL_W-1:0]         = ev_sel_q[rd_idx];
      end
      GRP_SMASK:  rd_data[STATE_W-1:0] = smask_q[rd_idx];
      default: ;
    endcase
  end

  // R8: an unobstructed boundary copies the shadow into match 0
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !cfg_norel && !(wr_en && wr_grp == GRP_MATCH))
      |=> (match_q[0] == $past(reload_q[0])));

  // R8: with reload suppressed match 0 is untouched by a boundary
  p_norel_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cfg_norel && !(wr_en && wr_grp == GRP_MATCH))
      |=> (match_q[0] == $past(match_q[0])));

  // R3: no count step while out of unified mode or halted
  p_no_step_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_en) |=> (cnt == $past(cnt)));

endmodule

// File: tb/test_event_match_timer.sv
module test_event_match_timer;

  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_CFG = 8'h00, A_CTRL = 8'h01, A_LIM = 8'h02, A_CNT = 8'h03;
  localparam logic [7:0] A_M0 = 8'h10, A_M1 = 8'h11, A_R0 = 8'h20, A_R1 = 8'h21;
  localparam logic [7:0] A_E0 = 8'h30, A_E1 = 8'h31, A_E2 = 8'h32;
  localparam logic [7:0] A_S0 = 8'h40, A_S1 = 8'h41, A_S2 = 8'h42;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic [15:0] ev_out;

  event_match_timer i_event_match_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_out(ev_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       req;
    logic [31:0] cnt;
    logic [15:0] ev;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic judge(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input string req, input int c, input int e);
    exp_t it;
    it.req = req;
    it.cnt = 32'(c);
    it.ev  = 16'(e);
    sb_q.push_back(it);
  endtask

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    exp_t it;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      judge({it.req, " count"}, rd_data, it.cnt);
      judge({it.req, " events"}, {16'h0, ev_out}, {16'h0, it.ev});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    judge(req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = A_CNT;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd_chk("R1 ctrl", A_CTRL, 32'h4);
    rd_chk("R1 cfg", A_CFG, 32'h0);
    rd_chk("R1 limit", A_LIM, 32'h0);
    rd_chk("R1 match", A_M0, 32'h0);
    rd_chk("R1 count", A_CNT, 32'h0);
    judge("R1 events", {16'h0, ev_out}, 32'h0);

    // R3: not unified, so even with halt clear nothing moves
    wr(A_CTRL, 32'h0);
    idle(3);
    rd_chk("R3 idle", A_CNT, 32'h0);
    wr(A_CTRL, 32'h4);

    // programming
    wr(A_CFG, 32'h1);
    wr(A_LIM, 32'h1);
    wr(A_M0, 32'd4); wr(A_R0, 32'd4);
    wr(A_M1, 32'd2); wr(A_R1, 32'd2);
    wr(A_E0, 32'h1000); wr(A_E1, 32'h1001); wr(A_E2, 32'h1001);
    wr(A_S0, 32'h1); wr(A_S1, 32'h1); wr(A_S2, 32'h1);
    rd_chk("R2 limit", A_LIM, 32'h1);
    rd_chk("R2 evctl", A_E2, 32'h1001);
    rd_chk("R2 smask", A_S1, 32'h1);
    rd_chk("R2 reload", A_R0, 32'd4);

    // R5 R6 R7: period of 5, events 1 and 2 at value 2, event 0 at value 4
    rd_addr = A_CNT;
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 15; i++)
      push("R5/R6/R7", i % 5, (i % 5 == 3) ? 6 : ((i % 5 == 0 && i > 0) ? 1 : 0));
    drain();

    // R10: halt freezes the count and silences events
    wr(A_CTRL, 32'h4);
    idle(1);
    rd_addr = A_CNT; #1;
    held = rd_data;
    for (int i = 0; i < 5; i++) push("R10 halt", int'(held), 0);
    drain();
    // R11: load while halted, sitting on a matching value without pulses
    wr(A_CNT, 32'd2);
    for (int i = 0; i < 4; i++) push("R11/R10 load", 2, 0);
    drain();

    // R4: prescale 2, one step every 3 clocks, one pulse per value
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h40);
    for (int i = 0; i < 18; i++)
      push("R4/R6", (i / 3) % 5, (i % 15 == 7) ? 6 : ((i % 15 == 13) ? 1 : 0));
    drain();
    wr(A_CTRL, 32'h4);

    // R8: reload of match 0 to 2 at the first boundary
    wr(A_CNT, 32'd0);
    wr(A_R0, 32'd2);
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 12; i++) begin
      int c, e;
      c = (i < 5) ? i : (i - 5) % 3;
      e = (i == 3) ? 6 : (i == 5) ? 1 : ((i >= 8 && (i - 8) % 3 == 0) ? 7 : 0);
      push("R8 reload", c, e);
    end
    drain();
    wr(A_CTRL, 32'h4);
    rd_chk("R8 reloaded", A_M0, 32'd2);

    // R8: reload suppressed by configuration bit 7
    wr(A_CFG, 32'h81);
    wr(A_R0, 32'd3);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0);
    idle(10);
    wr(A_CTRL, 32'h4);
    rd_chk("R8 no-reload", A_M0, 32'd2);
    rd_chk("R2 cfg", A_CFG, 32'h81);
    wr(A_CFG, 32'h1);

    // R8: write lands on the boundary edge (third edge after run) and wins
    wr(A_CNT, 32'd0);
    wr(A_R0, 32'd1);
    wr(A_M0, 32'd2);
    wr(A_CTRL, 32'h0);
    idle(2);
    wr(A_M0, 32'd5);
    wr(A_CTRL, 32'h4);
    rd_chk("R8 write-over-reload", A_M0, 32'd5);

    // R9 + R5 disables: up/down between 0 and 3, only event 0 may fire
    wr(A_CNT, 32'd0);
    wr(A_M0, 32'd3);
    wr(A_R0, 32'd3);
    wr(A_E1, 32'h0);
    wr(A_S2, 32'h0);
    rd_addr = A_CNT;
    wr(A_CTRL, 32'h10);
    for (int i = 0; i < 14; i++) begin
      int m;
      m = i % 6;
      push("R9/R5", (m <= 3) ? m : 6 - m, (m == 4) ? 1 : 0);
    end
    drain();
    wr(A_CTRL, 32'h14);
    rd_chk("R9 ctrl", A_CTRL, 32'h14);

    done = 1'b1;
    finish_run();
  end

endmodule